// File: doc/BRIEF.md
# Stream Frame to Register Bank Receiver

This block terminates a stream of 32-bit words that arrive in frames, each frame closed by a `last` marker, and presents the frame contents to a host as a bank of 16-bit readable registers. Every received word is split into two halves that sit side by side in the bank. A dedicated register, and a separate count port, report how many words the most recent frame carried. Frames are assumed to have been validated upstream, and the block runs in a single clock domain.

Incoming words are first gathered in a private shadow buffer, so the host never sees a half-written frame. When the closing beat is accepted, the whole frame is copied into the visible bank in one clock edge. An update strobe marks the exact cycle the new contents appear, so the host can sample a coherent set of values on that pulse. A synchronous restart input drops any frame in progress and clears everything. A configuration input chooses how the bytes of each incoming word are ordered.

Top module: `frame_rx_regs`

## Requirements
- R1: Word k of a frame (k counted from 0) appears with bits [15:0] in register 2k and bits [31:16] in register 2k+1, where register r occupies `reg_file[16r+15:16r]`.
- R2: Register 255 (zero-extended) and the `rx_count` port both hold the number of words in the last published frame, saturating at 32.
- R3: Only the first 32 words of a frame are stored. Words after the 32nd are dropped, and registers 0 to 63 then hold words 0 to 31.
- R4: The visible registers change only on the clock edge that accepts a beat with `s_tvalid` and `s_tlast` both high. Beats that do not close a frame leave the visible registers unchanged.
- R5: `rx_upd` is high for exactly the one cycle that follows the accepted closing beat. This is the same cycle in which the new values are first visible, and it is low in every other cycle.
- R6: While `restart` is high at a clock edge, the frame in progress is dropped, all registers and the count become zero, and a beat presented in the same cycle is ignored.
- R7: With `big_endian`=0 a word is stored as received. With `big_endian`=1 its bytes are reversed before storage (bits [7:0] swap with [31:24], and [15:8] swap with [23:16]). The setting is sampled on each beat.
- R8: `s_tready` is always 1.
- R9: A frame of n words rewrites only words 0 to n-1. Registers of higher-numbered words keep the values they had before.
- R10: Registers 64 to 254 always read zero.
- R11: A cycle with `s_tvalid` low neither stores a word nor publishes a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous clear pulse |
| big_endian | input | 1 | 1 = reverse the byte order of each incoming word |
| s_tdata | input | 32 | Stream data word |
| s_tvalid | input | 1 | Stream beat valid |
| s_tlast | input | 1 | Last beat of the frame |
| s_tready | output | 1 | Stream ready, tied high |
| reg_file | output | 4096 | 256 registers of 16 bits, register r at bits [16r+15:16r] |
| rx_count | output | 6 | Word count of the last published frame |
| rx_upd | output | 1 | One-cycle update strobe |

## Verification
The bench builds the block with its default parameters: 32-bit words, 16-bit registers, 32 word slots and a bank of 256 registers. With these values, frames longer than 32 words reach count saturation, and the never-written region from 64 to 254 can be checked. A behavioural queue model is compared with the whole bank, the count and the strobe on every cycle. This covers frames with gaps in `s_tvalid`, back-to-back closing beats, both byte orders, short frames after long ones, and a restart both in the middle of a frame and on the closing beat.

// File: rtl/frx_pkg.sv
package frx_pkg;
   typedef enum logic {
      ORDER_AS_IS   = 1'b0,
      ORDER_SWAPPED = 1'b1
   } order_e;

   localparam int BYTE_W = 8;
endpackage

// File: rtl/frx_order.sv
module frx_order #(
   parameter int DATA_W = 32
) (
   input  logic              big_endian,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   import frx_pkg::*;
   localparam int NBYTES = DATA_W / BYTE_W;

   if (DATA_W % BYTE_W != 0) begin : g_bad_width
      $error("frx_order: DATA_W must be a multiple of 8");
   end

   order_e mode;
   assign mode = order_e'(big_endian);

   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign dout[b*BYTE_W +: BYTE_W] = (mode == ORDER_SWAPPED)
                                        ? din[(NBYTES-1-b)*BYTE_W +: BYTE_W]
                                        : din[b*BYTE_W +: BYTE_W];
   end
endmodule

// File: rtl/frx_shadow.sv
module frx_shadow #(
   parameter int DATA_W  = 32,
   parameter int MAX_SIG = 32,
   parameter int IDX_W   = $clog2(MAX_SIG + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      restart,
   input  logic                      beat_vld,
   input  logic                      beat_last,
   input  logic [DATA_W-1:0]         beat_word,
   output logic                      pub,
   output logic [IDX_W-1:0]          pub_cnt,
   output logic [MAX_SIG*DATA_W-1:0] pub_words
);
   localparam int SLOT_W = $clog2(MAX_SIG);
   localparam logic [IDX_W-1:0] FULL = IDX_W'(MAX_SIG);

   logic [DATA_W-1:0] buf_q [MAX_SIG];
   logic [IDX_W-1:0]  idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         for (int k = 0; k < MAX_SIG; k++) buf_q[k] <= '0;
      end else if (restart) begin
         idx_q <= '0;
         for (int k = 0; k < MAX_SIG; k++) buf_q[k] <= '0;
      end else if (beat_vld) begin
         if (idx_q < FULL) buf_q[idx_q[SLOT_W-1:0]] <= beat_word;
         if (beat_last)          idx_q <= '0;
         else if (idx_q != FULL) idx_q <= idx_q + IDX_W'(1);
      end
   end

   // merged view: stored words plus the word arriving on this beat
   for (genvar k = 0; k < MAX_SIG; k++) begin : g_merge
      assign pub_words[k*DATA_W +: DATA_W] =
         (beat_vld && idx_q == IDX_W'(k)) ? beat_word : buf_q[k];
   end

   assign pub     = beat_vld && beat_last && !restart;
   assign pub_cnt = (idx_q == FULL) ? FULL : idx_q + IDX_W'(1);

   // R3: write pointer never passes the last slot plus one
   p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= FULL);

   // R6: a restart leaves the pointer at the first slot
   p_restart_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> idx_q == '0);
endmodule

// File: rtl/frx_visible.sv
module frx_visible #(
   parameter int DATA_W   = 32,
   parameter int HALF_W   = 16,
   parameter int MAX_SIG  = 32,
   parameter int NREG     = 256,
   parameter int CNT_ADDR = 255,
   parameter int IDX_W    = $clog2(MAX_SIG + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      restart,
   input  logic                      pub,
   input  logic [IDX_W-1:0]          pub_cnt,
   input  logic [MAX_SIG*DATA_W-1:0] pub_words,
   output logic [NREG*HALF_W-1:0]    regs_flat,
   output logic [IDX_W-1:0]          count,
   output logic                      upd
);
   localparam int MAP_END = 2 * MAX_SIG;
   localparam logic [IDX_W-1:0] FULL = IDX_W'(MAX_SIG);

   logic [DATA_W-1:0] words_q [MAX_SIG];
   logic [IDX_W-1:0]  cnt_q;
   logic              upd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         upd_q <= 1'b0;
         for (int k = 0; k < MAX_SIG; k++) words_q[k] <= '0;
      end else if (restart) begin
         cnt_q <= '0;
         upd_q <= 1'b0;
         for (int k = 0; k < MAX_SIG; k++) words_q[k] <= '0;
      end else begin
         upd_q <= pub;
         if (pub) begin
            cnt_q <= pub_cnt;
            for (int k = 0; k < MAX_SIG; k++)
               if (IDX_W'(k) < pub_cnt) words_q[k] <= pub_words[k*DATA_W +: DATA_W];
         end
      end
   end

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      if (r < MAP_END) begin : g_map
         localparam int W = r / 2;
         if (r % 2 == 1) begin : g_hi
            assign regs_flat[r*HALF_W +: HALF_W] = words_q[W][DATA_W-1:HALF_W];
         end else begin : g_lo
            assign regs_flat[r*HALF_W +: HALF_W] = words_q[W][HALF_W-1:0];
         end
      end else if (r == CNT_ADDR) begin : g_cnt
         assign regs_flat[r*HALF_W +: HALF_W] = {{(HALF_W-IDX_W){1'b0}}, cnt_q};
      end else begin : g_zero
         assign regs_flat[r*HALF_W +: HALF_W] = '0;
      end
   end

   assign count = cnt_q;
   assign upd   = upd_q;

   // R4: outside a publish or restart the bank holds still
   p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_q && !$past(restart)) |-> $stable(regs_flat));

   // R5: strobe only follows an accepted closing beat
   p_strobe_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      upd_q |-> $past(pub));

   // R2: count saturates at the slot count
   p_cnt_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL);

   // R6: restart clears the count and suppresses the strobe
   p_restart_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_q == '0 && !upd_q));
endmodule

// File: rtl/frame_rx_regs.sv
module frame_rx_regs #(
   parameter int DATA_W   = 32,
   parameter int HALF_W   = 16,
   parameter int MAX_SIG  = 32,
   parameter int NREG     = 256,
   parameter int CNT_ADDR = 255,
   localparam int IDX_W   = $clog2(MAX_SIG + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   restart,
   input  logic                   big_endian,
   input  logic [DATA_W-1:0]      s_tdata,
   input  logic                   s_tvalid,
   input  logic                   s_tlast,
   output logic                   s_tready,
   output logic [NREG*HALF_W-1:0] reg_file,
   output logic [IDX_W-1:0]       rx_count,
   output logic                   rx_upd
);
   if (DATA_W != 2 * HALF_W) begin : g_chk_half
      $error("frame_rx_regs: DATA_W must be twice HALF_W");
   end
   if (MAX_SIG < 2) begin : g_chk_sig
      $error("frame_rx_regs: MAX_SIG must be at least 2");
   end
   if (2 * MAX_SIG > CNT_ADDR || CNT_ADDR >= NREG) begin : g_chk_map
      $error("frame_rx_regs: count register must lie above the word map and inside the bank");
   end
   if (IDX_W > HALF_W) begin : g_chk_cnt
      $error("frame_rx_regs: count does not fit one register");
   end

   logic [DATA_W-1:0]         word_ord;
   logic                      pub;
   logic [IDX_W-1:0]          pub_cnt;
   logic [MAX_SIG*DATA_W-1:0] pub_words;

   assign s_tready = 1'b1;

   frx_order #(.DATA_W(DATA_W)) u_order (
      .big_endian (big_endian),
      .din        (s_tdata),
      .dout       (word_ord)
   );

   frx_shadow #(.DATA_W(DATA_W), .MAX_SIG(MAX_SIG), .IDX_W(IDX_W)) u_shadow (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (restart),
      .beat_vld  (s_tvalid),
      .beat_last (s_tlast),
      .beat_word (word_ord),
      .pub       (pub),
      .pub_cnt   (pub_cnt),
      .pub_words (pub_words)
   );

   frx_visible #(.DATA_W(DATA_W), .HALF_W(HALF_W), .MAX_SIG(MAX_SIG),
                 .NREG(NREG), .CNT_ADDR(CNT_ADDR), .IDX_W(IDX_W)) u_visible (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (restart),
      .pub       (pub),
      .pub_cnt   (pub_cnt),
      .pub_words (pub_words),
      .regs_flat (reg_file),
      .count     (rx_count),
      .upd       (rx_upd)
   );

   // R8: the stream is never back-pressured
   p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      s_tvalid |-> s_tready);
endmodule

// File: tb/frame_rx_regs_bench.sv
module frame_rx_regs_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic restart = 1'b0;
   logic big_endian = 1'b0;
   logic [31:0] s_tdata = '0;
   logic s_tvalid = 1'b0;
   logic s_tlast = 1'b0;
   logic s_tready;
   logic [4095:0] reg_file;
   logic [5:0] rx_count;
   logic rx_upd;

   int checks = 0;
   int fails = 0;
   bit running = 1'b0;

   always #5 clk = ~clk;

   frame_rx_regs u_frame_rx_regs (
      .clk(clk), .rst_n(rst_n), .restart(restart), .big_endian(big_endian),
      .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast),
      .s_tready(s_tready), .reg_file(reg_file), .rx_count(rx_count), .rx_upd(rx_upd)
   );

   // behavioural reference model
   logic [31:0] mq[$];
   logic [31:0] mvis[32];
   int mcnt = 0;
   bit mupd = 1'b0;

   initial for (int k = 0; k < 32; k++) mvis[k] = '0;

   always @(posedge clk) begin
      logic [31:0] w;
      if (!rst_n || restart) begin
         mq.delete();
         for (int k = 0; k < 32; k++) mvis[k] = '0;
         mcnt = 0;
         mupd = 1'b0;
      end else begin
         mupd = 1'b0;
         if (s_tvalid) begin
            w = big_endian ? {s_tdata[7:0], s_tdata[15:8], s_tdata[23:16], s_tdata[31:24]}
                           : s_tdata;
            if (mq.size() < 32) mq.push_back(w);
            if (s_tlast) begin
               for (int k = 0; k < mq.size(); k++) mvis[k] = mq[k];
               mcnt = mq.size();
               mupd = 1'b1;
               mq.delete();
            end
         end
      end
   end

   function automatic logic [15:0] exp_reg(int r);
      if (r < 64) return (r % 2 == 1) ? mvis[r/2][31:16] : mvis[r/2][15:0];
      if (r == 255) return 16'(mcnt);
      return 16'h0;
   endfunction

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (running && rst_n) begin
         bit ok_map = 1'b1, ok_zero = 1'b1;
         int bad_map = 0, bad_zero = 0;
         for (int r = 0; r < 256; r++) begin
            if (reg_file[r*16 +: 16] !== exp_reg(r)) begin
               if (r < 64 || r == 255) begin ok_map = 1'b0; bad_map = r; end
               else begin ok_zero = 1'b0; bad_zero = r; end
            end
         end
         check(ok_map, $sformatf("R1 R2 R4 R9 reg %0d", bad_map),
               32'(reg_file[bad_map*16 +: 16]), 32'(exp_reg(bad_map)));
         check(ok_zero, $sformatf("R10 reg %0d", bad_zero),
               32'(reg_file[bad_zero*16 +: 16]), 32'h0);
         check(rx_count == 6'(mcnt), "R2 rx_count", 32'(rx_count), 32'(mcnt));
         check(rx_upd == mupd, "R5 rx_upd", 32'(rx_upd), 32'(mupd));
         check(s_tready == 1'b1, "R8 s_tready", 32'(s_tready), 32'h1);
      end
   end

   task automatic beat(logic [31:0] d, bit last);
      @(negedge clk);
      s_tvalid = 1'b1; s_tdata = d; s_tlast = last;
   endtask

   task automatic gap();
      @(negedge clk);
      s_tvalid = 1'b0; s_tlast = 1'b0; s_tdata = 32'hDEAD_BEEF;
   endtask

   task automatic reg_is(int r, logic [15:0] v, string tag);
      #1 check(reg_file[r*16 +: 16] === v, tag, 32'(reg_file[r*16 +: 16]), 32'(v));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // reset state
      check(reg_file === '0, "R6 reset bank zero", 32'(reg_file[31:0]), 32'h0);
      check(rx_upd === 1'b0, "R5 reset strobe low", 32'(rx_upd), 32'h0);
      rst_n = 1'b1;
      running = 1'b1;

      // little-endian three-word frame with a gap (R1, R7, R11)
      beat(32'hA1B2C3D4, 1'b0);
      gap();
      beat(32'h01020304, 1'b0);
      beat(32'h55667788, 1'b1);
      reg_is(0, 16'h0, "R4 not visible before publish");
      gap();
      reg_is(0, 16'hC3D4, "R1 word0 low half");
      reg_is(1, 16'hA1B2, "R1 word0 high half");
      reg_is(255, 16'd3, "R2 count three");
      check(rx_upd === 1'b1, "R5 strobe with new data", 32'(rx_upd), 32'h1);
      gap();
      check(rx_upd === 1'b0, "R5 strobe one cycle", 32'(rx_upd), 32'h0);

      // big-endian frame (R7)
      big_endian = 1'b1;
      beat(32'h11223344, 1'b0);
      beat(32'hCAFEF00D, 1'b1);
      gap();
      reg_is(0, 16'h2211, "R7 swapped low half");
      reg_is(1, 16'h4433, "R7 swapped high half");
      reg_is(4, 16'h7788, "R9 word2 kept from earlier frame");
      big_endian = 1'b0;

      // 40-word frame: saturation (R3, R2)
      for (int k = 0; k < 40; k++) beat(32'h1000_0000 + 32'(k), k == 39);
      gap();
      reg_is(62, 16'd31, "R3 word31 is 32nd word");
      reg_is(255, 16'd32, "R2 count saturates");

      // back-to-back single-word frames
      beat(32'hAAAA_0001, 1'b1);
      beat(32'hBBBB_0002, 1'b1);
      gap();
      reg_is(0, 16'h0002, "R9 single word frame");
      reg_is(2, 16'h0001, "R9 word1 kept");

      // restart mid-frame (R6)
      beat(32'h7777_7777, 1'b0);
      @(negedge clk); s_tvalid = 1'b0; restart = 1'b1;
      @(negedge clk); restart = 1'b0;
      #1 check(rx_count === 6'd0, "R6 restart clears count", 32'(rx_count), 32'h0);
      reg_is(0, 16'h0, "R6 restart clears bank");
      beat(32'h0000_1234, 1'b1);
      gap();
      reg_is(0, 16'h1234, "R6 partial frame dropped");
      reg_is(255, 16'd1, "R6 count after restart");

      // restart on the closing beat (R6)
      beat(32'h9999_9999, 1'b0);
      @(negedge clk); s_tvalid = 1'b1; s_tlast = 1'b1; s_tdata = 32'h8888_8888; restart = 1'b1;
      @(negedge clk); s_tvalid = 1'b0; s_tlast = 1'b0; restart = 1'b0;
      #1 check(rx_upd === 1'b0, "R6 closing beat ignored", 32'(rx_upd), 32'h0);
      reg_is(255, 16'd0, "R6 count zero");

      // tlast with tvalid low must not publish (R11)
      @(negedge clk); s_tvalid = 1'b0; s_tlast = 1'b1;
      @(negedge clk); s_tlast = 1'b0;
      #1 check(rx_upd === 1'b0, "R11 idle tlast ignored", 32'(rx_upd), 32'h0);
      repeat (4) gap();

      running = 1'b0;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule